// File: doc/BRIEF.md
# Two-Bit-Per-Slice Carry-Multiplexer Arithmetic Chain

This block is a cascadable ripple arithmetic unit built from identical slices, each covering two adjacent bit positions. In every bit position a small lookup function forms a half-sum. A carry multiplexer then either passes the incoming carry on (propagate) or substitutes a local generate term. A dedicated XOR of the half-sum with the incoming carry completes the sum bit. The lower bit of a slice hands its carry to the upper bit, and the upper bit's carry feeds the next slice. The first slice takes its carry from a carry-in port, and the carry out of the last slice is the block's carry-out.

A mode input selects between two uses of the same chain. In add mode the chain computes `opa + opb + cin`. Subtraction uses the same path, with an inverted operand and the carry-in set to 1. In multiply mode the chain adds one row of an array multiplier: two shifted AND partial-product vectors formed from `opa` and the two low bits of `opb`. In this mode a separate two-input AND copies one partial product as the generate term.

Each sum bit is available combinationally. It is also available through an optional output register with a synchronous active-low reset. A configuration mask can pin the carry-mux select of chosen bit positions to "always propagate".

Top module: `carry_chain_arith`

## Requirements
- R1: With `mode` = 0 (add), `{cout, sum_comb}` equals `opa + opb + cin`, computed WIDTH+1 bits wide.
- R2: Subtraction works through the same path: with `opb` driven as the bitwise inverse of a subtrahend `y` and `cin` = 1, `sum_comb` = `opa - y` modulo 2^WIDTH, and `cout` = 1 exactly when `opa >= y`.
- R3: A carry entering bit 0 ripples through every slice boundary. For example, all-ones plus zero with `cin` = 1 gives `sum_comb` = 0 and `cout` = 1.
- R4: With `mode` = 1 (multiply row), `{cout, sum_comb}` equals `(opa & {WIDTH{opb[0]}}) + ((opa << 1) truncated to WIDTH bits & {WIDTH{opb[1]}}) + cin`, computed WIDTH+1 bits wide.
- R5: In multiply mode, `opb[WIDTH-1:2]` has no effect on `sum_comb`, `cout` or `sum_q`.
- R6: With REG_OUT = 1 and `rst_n` high at a rising edge, `sum_q` after that edge equals the `sum_comb` value present just before it.
- R7: A rising edge with `rst_n` low sets `sum_q` to zero. `sum_comb` and `cout` keep giving the correct arithmetic result while reset is held.
- R8: With REG_OUT = 0, `sum_q` follows `sum_comb` in the same cycle, with no clock involved.
- R9: For a bit i whose FORCE_PROP_MASK bit is 1, the carry out of bit i equals the carry into bit i, and sum bit i is that bit's lookup output XOR the carry into it. The lookup output is `opa[i]^opb[i]` in add mode and `(opa[i-1]&opb[1]) ^ (opa[i]&opb[0])` in multiply mode, with `opa[-1]` = 0. Every other bit forms its carry as the full-add carry of its two terms and its carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional sum register |
| rst_n | input | 1 | Synchronous active-low reset of the sum register |
| mode | input | 1 | 0 = add operands, 1 = add one multiplier row |
| opa | input | WIDTH | Addend, or multiplicand in multiply mode |
| opb | input | WIDTH | Addend; in multiply mode only bits 1:0 (multiplier bits) are used |
| cin | input | 1 | Carry into bit 0 |
| sum_comb | output | WIDTH | Combinational sum |
| sum_q | output | WIDTH | Registered sum (or the combinational sum when REG_OUT = 0) |
| cout | output | 1 | Carry out of the top bit |

## Verification
The arithmetic properties compare the outputs against plain additions at each rising edge. They assume that `mode`, `opa`, `opb` and `cin` are settled and unchanged around that edge, and they are only built when no bit position has forced propagation. The register properties assume that `rst_n` is low from time zero. The stimulus respects all of this: every input, `rst_n` included, changes only on the falling clock edge, and reset is held from the start. The forced-propagation variant is checked only by the bench, through its own per-bit reference.

// File: rtl/cca_pkg.sv
package cca_pkg;

   typedef enum logic {
      OPM_ADD = 1'b0,
      OPM_MUL = 1'b1
   } opmode_e;

   // Lookup inputs of one bit position.
   // Add mode: pa = A[i], pb = B[i].
   // Multiply mode: pa = A[m], pb = B[n+1], qa = A[m+1], qb = B[n].
   typedef struct packed {
      logic pa;
      logic pb;
      logic qa;
      logic qb;
   } lk_t;

endpackage

// File: rtl/cca_half.sv
module cca_half
   import cca_pkg::*;
#(
   parameter bit FORCE_PROP = 1'b0
) (
   input  opmode_e mode,
   input  lk_t     lk,
   input  logic    cy_in,
   output logic    sum_o,
   output logic    cy_out
);

   logic half_sum;
   logic mult_and;
   logic gen;
   logic sel;

   // lookup function and the dedicated partial-product AND
   always_comb begin
      mult_and = lk.pa & lk.pb;
      if (mode == OPM_MUL) begin
         half_sum = mult_and ^ (lk.qa & lk.qb);
         gen      = mult_and;
      end else begin
         half_sum = lk.pa ^ lk.pb;
         gen      = lk.pa;
      end
   end

   // carry-mux select source is fixed by configuration
   generate
      if (FORCE_PROP) begin : g_sel_const
         assign sel = 1'b1;
      end else begin : g_sel_lut
         assign sel = half_sum;
      end
   endgenerate

   assign cy_out = sel ? cy_in : gen;
   assign sum_o  = half_sum ^ cy_in;

endmodule

// File: rtl/cca_slice.sv
module cca_slice
   import cca_pkg::*;
#(
   parameter bit FORCE_LO = 1'b0,
   parameter bit FORCE_HI = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  opmode_e    mode,
   input  lk_t        lk_lo,
   input  lk_t        lk_hi,
   input  logic       cin,
   output logic [1:0] sum,
   output logic       cout
);

   logic cy_mid;

   cca_half #(.FORCE_PROP(FORCE_LO)) u_lo (
      .mode   (mode),
      .lk     (lk_lo),
      .cy_in  (cin),
      .sum_o  (sum[0]),
      .cy_out (cy_mid)
   );

   cca_half #(.FORCE_PROP(FORCE_HI)) u_hi (
      .mode   (mode),
      .lk     (lk_hi),
      .cy_in  (cy_mid),
      .sum_o  (sum[1]),
      .cy_out (cout)
   );

   generate
      if (!FORCE_LO && !FORCE_HI) begin : g_chk
         // R1 R3: the two-bit slice behaves as a 2-bit adder with carry
         r1_slice_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == OPM_ADD) |->
            ({cout, sum} == ({2'b0, lk_lo.pa} + {2'b0, lk_lo.pb} + {2'b0, cin}
                           + {1'b0, lk_hi.pa, 1'b0} + {1'b0, lk_hi.pb, 1'b0})));
         // R4
         r4_slice_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == OPM_MUL) |->
            ({cout, sum} == ({2'b0, lk_lo.pa & lk_lo.pb} + {2'b0, lk_lo.qa & lk_lo.qb}
                           + {2'b0, cin}
                           + {1'b0, lk_hi.pa & lk_hi.pb, 1'b0}
                           + {1'b0, lk_hi.qa & lk_hi.qb, 1'b0})));
      end
   endgenerate

endmodule

// File: rtl/cca_sumreg.sv
module cca_sumreg #(
   parameter int WIDTH   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end

         // R6
         r6_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (q == $past(d)));
         // R7
         r7_reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (q == '0));
      end else begin : g_thru
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/carry_chain_arith.sv
module carry_chain_arith
   import cca_pkg::*;
#(
   parameter int               WIDTH           = 8,
   parameter bit               REG_OUT         = 1'b1,
   parameter logic [WIDTH-1:0] FORCE_PROP_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             cin,
   output logic [WIDTH-1:0] sum_comb,
   output logic [WIDTH-1:0] sum_q,
   output logic             cout
);

   localparam int NSLICE = WIDTH / 2;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("carry_chain_arith: WIDTH must be at least 2");
      end
      if ((WIDTH % 2) != 0) begin : g_bad_parity
         $error("carry_chain_arith: WIDTH must be even (two bits per slice)");
      end
   endgenerate

   opmode_e          mode_e;
   lk_t              lk [WIDTH];
   logic [NSLICE:0]  cy;

   assign mode_e = opmode_e'(mode);
   assign cy[0]  = cin;

   // lookup input routing per bit position
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic a_below;
         if (i == 0) begin : g_first
            assign a_below = 1'b0;
         end else begin : g_rest
            assign a_below = opa[i-1];
         end
         always_comb begin
            if (mode_e == OPM_MUL) begin
               lk[i].pa = a_below;
               lk[i].pb = opb[1];
            end else begin
               lk[i].pa = opa[i];
               lk[i].pb = opb[i];
            end
            lk[i].qa = opa[i];
            lk[i].qb = opb[0];
         end
      end
   endgenerate

   // ripple of two-bit slices
   generate
      for (genvar s = 0; s < NSLICE; s++) begin : g_slice
         cca_slice #(
            .FORCE_LO (FORCE_PROP_MASK[2*s]),
            .FORCE_HI (FORCE_PROP_MASK[2*s+1])
         ) u_slice (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (mode_e),
            .lk_lo (lk[2*s]),
            .lk_hi (lk[2*s+1]),
            .cin   (cy[s]),
            .sum   (sum_comb[2*s+1:2*s]),
            .cout  (cy[s+1])
         );
      end
   endgenerate

   assign cout = cy[NSLICE];

   cca_sumreg #(
      .WIDTH   (WIDTH),
      .REG_OUT (REG_OUT)
   ) u_sumreg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sum_comb),
      .q     (sum_q)
   );

   generate
      if (FORCE_PROP_MASK == '0) begin : g_chk
         // R1
         r1_add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 1'b0) |->
            ({cout, sum_comb} == ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin})));
         // R4
         r4_mul_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == 1'b1) |->
            ({cout, sum_comb} == ({1'b0, opa & {WIDTH{opb[0]}}}
                                + {1'b0, (opa << 1) & {WIDTH{opb[1]}}}
                                + {{WIDTH{1'b0}}, cin})));
      end
   endgenerate

endmodule

// File: tb/tb_carry_chain_arith.sv
`timescale 1ns/1ps
module tb_carry_chain_arith;

   localparam int W = 8;
   localparam logic [W-1:0] FP_MASK = 8'h24;

   typedef struct {
      logic [W:0] exp;
      logic [W:0] fp_exp;
      logic       in_rst;
      string      tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode = 1'b0;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum_comb, sum_q, fp_sum_comb, fp_sum_q;
   logic         cout, fp_cout;

   int n_cmp = 0;
   int n_bad = 0;
   item_t sb[$];

   always #5 clk = ~clk;

   carry_chain_arith #(.WIDTH(W), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .opa(opa), .opb(opb), .cin(cin),
      .sum_comb(sum_comb), .sum_q(sum_q), .cout(cout)
   );

   carry_chain_arith #(.WIDTH(W), .REG_OUT(1'b0), .FORCE_PROP_MASK(FP_MASK)) dut_fp (
      .clk(clk), .rst_n(rst_n), .mode(mode), .opa(opa), .opb(opb), .cin(cin),
      .sum_comb(fp_sum_comb), .sum_q(fp_sum_q), .cout(fp_cout)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // R1 R4: plain arithmetic reference
   function automatic logic [W:0] ref_arith(input logic m, input logic [W-1:0] a,
                                            input logic [W-1:0] b, input logic c);
      if (m) return {1'b0, a & {W{b[0]}}} + {1'b0, (a << 1) & {W{b[1]}}} + {{W{1'b0}}, c};
      else   return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
   endfunction

   // R9: per-bit reference with forced-propagate positions
   function automatic logic [W:0] ref_forced(input logic m, input logic [W-1:0] a,
                                             input logic [W-1:0] b, input logic c,
                                             input logic [W-1:0] msk);
      logic [W-1:0] s;
      logic         cy;
      cy = c;
      for (int i = 0; i < W; i++) begin
         logic t0, t1, lk, nc;
         if (m) begin
            t0 = (i == 0) ? 1'b0 : (a[i-1] & b[1]);
            t1 = a[i] & b[0];
         end else begin
            t0 = a[i];
            t1 = b[i];
         end
         lk   = t0 ^ t1;
         s[i] = lk ^ cy;
         nc   = msk[i] ? cy : ((t0 & t1) | (t0 & cy) | (t1 & cy));
         cy   = nc;
      end
      return {cy, s};
   endfunction

   // driver: applies inputs on the falling edge and queues the expectation
   task automatic drive(input logic rv, input logic m, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic c, input string tag);
      item_t it;
      @(negedge clk);
      rst_n = rv;
      mode  = m;
      opa   = a;
      opb   = b;
      cin   = c;
      it.exp    = ref_arith(m, a, b, c);
      it.fp_exp = ref_forced(m, a, b, c, FP_MASK);
      it.in_rst = !rv;
      it.tag    = tag;
      sb.push_back(it);
   endtask

   // monitor: one item per rising edge, sampled 1 ns after it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk({it.tag, " comb result"}, {23'b0, cout, sum_comb}, {23'b0, it.exp});
            if (it.in_rst)
               chk("R7 sum_q cleared by reset", {24'b0, sum_q}, 32'h0);
            else
               chk({"R6 registered sum (", it.tag, ")"}, {24'b0, sum_q}, {24'b0, it.exp[W-1:0]});
            chk({"R9 forced-propagate chain (", it.tag, ")"}, {23'b0, fp_cout, fp_sum_comb},
                {23'b0, it.fp_exp});
            chk("R8 unregistered sum_q", {24'b0, fp_sum_q}, {24'b0, it.fp_exp[W-1:0]});
         end
      end
   end

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R7 sum_q zero after reset", {24'b0, sum_q}, 32'h0);
      // arithmetic valid while reset is held
      drive(1'b0, 1'b0, 8'h3c, 8'h0f, 1'b1, "R7 add under reset");
      drive(1'b0, 1'b1, 8'h5a, 8'h03, 1'b0, "R7 mul under reset");
      // add-mode corners
      drive(1'b1, 1'b0, 8'h00, 8'h00, 1'b0, "R1 zero");
      drive(1'b1, 1'b0, 8'hff, 8'hff, 1'b1, "R1 all ones");
      drive(1'b1, 1'b0, 8'haa, 8'h55, 1'b0, "R1 alternating");
      drive(1'b1, 1'b0, 8'haa, 8'h55, 1'b1, "R3 alternating with carry");
      drive(1'b1, 1'b0, 8'hff, 8'h00, 1'b1, "R3 full ripple");
      drive(1'b1, 1'b0, 8'hff, 8'h01, 1'b0, "R3 ripple from operand");
      // subtraction
      drive(1'b1, 1'b0, 8'h50, ~8'h20, 1'b1, "R2 sub no borrow");
      drive(1'b1, 1'b0, 8'h20, ~8'h50, 1'b1, "R2 sub borrow");
      drive(1'b1, 1'b0, 8'h77, ~8'h77, 1'b1, "R2 sub equal");
      // multiply rows
      drive(1'b1, 1'b1, 8'hff, 8'h03, 1'b0, "R4 row all ones");
      drive(1'b1, 1'b1, 8'hb6, 8'h01, 1'b1, "R4 row y0 only");
      drive(1'b1, 1'b1, 8'hb6, 8'h02, 1'b0, "R4 row y1 only");
      drive(1'b1, 1'b1, 8'h00, 8'h03, 1'b1, "R4 row zero multiplicand");
      // upper opb bits ignored in multiply mode
      drive(1'b1, 1'b1, 8'h9d, 8'h03, 1'b0, "R5 high bits clear");
      drive(1'b1, 1'b1, 8'h9d, 8'hff, 1'b0, "R5 high bits set");
      drive(1'b1, 1'b1, 8'h9d, 8'h57, 1'b1, "R5 high bits mixed");
      // mid-run reset
      drive(1'b0, 1'b0, 8'h12, 8'h34, 1'b0, "R7 mid-run reset");
      drive(1'b1, 1'b0, 8'h12, 8'h34, 1'b0, "R6 after reset release");
      // random
      for (int k = 0; k < 200; k++) begin
         logic [31:0] r;
         r = $urandom;
         drive(1'b1, r[24], r[7:0], r[15:8], r[16], r[24] ? "R4 random" : "R1 random");
      end
      repeat (3) @(posedge clk);
      #2;
      chk("R1 scoreboard drained", sb.size(), 32'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule